// File: doc/BRIEF.md
# Management Interface Clock Divider

This block generates the management data clock (MDC) for an Ethernet MII management port from the internal bus clock. Software programs a divide value and a preamble-skip flag through a small single-cycle register port. MDC then runs at the bus clock frequency divided by twice the divide value, with a 50% duty cycle. A divide value of zero parks MDC at logic low.

Alongside MDC the block produces four further outputs. The first is a one-cycle strobe on every MDC transition, tagged rising or falling, which a downstream management frame engine uses as its clock enable. The second is a running flag that tells the engine whether a frame may be started. The third is the stored preamble-skip flag, which tells the engine to leave out the 32-ones preamble. A new divide value only takes effect when the current MDC half-phase ends, so MDC never produces a runt pulse.

The register port has no back-pressure. Every access completes in the cycle it is presented, and read data is a combinational function of the address. No valid/ready stream exists at this block's edge, because the strobe is a plain enable with no handshake.

Top module: `mdc_clk_divider`

## Requirements
- R1: After reset, MDC is low, the strobe is low, the running flag is low, the preamble-skip output is low, and the control register reads zero.
- R2: The control register sits at address CTRL_ADDR (default 0x44). The divide value is in bits [6:1] and the preamble-skip flag is bit 7, and both read back as written. All other bits read zero. Reads of other addresses return zero, and writes to them leave the control register unchanged.
- R3: While the divide value is zero and MDC is low, MDC stays low and no strobe occurs.
- R4: For a non-zero divide value N in steady operation, MDC stays high for exactly N bus cycles and low for exactly N bus cycles.
- R5: From the stopped state, MDC first goes high on the (N+1)th bus-clock edge after the edge that captures the write of N.
- R6: A divide value written while MDC runs does not change the length of the half-phase in progress. All half-phases that follow last the new value.
- R7: Writing zero while MDC is high lets the high phase finish with its old length, then MDC falls and stays low. Writing zero while MDC is low keeps it low.
- R8: The strobe is high for exactly the cycles in which MDC shows a new level. The edge tag is 1 for a rising edge and 0 for a falling edge.
- R9: The running flag equals (divide value != 0) from the cycle after the write. The preamble-skip output equals control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational) |
| mdc | output | 1 | Management data clock |
| mdc_stb | output | 1 | One-cycle pulse on each MDC transition |
| mdc_stb_rise | output | 1 | Edge tag for the strobe: 1 rising, 0 falling |
| clk_running | output | 1 | Divide value is non-zero; frames may start |
| skip_preamble | output | 1 | Frame engine omits the preamble |

## Verification
The in-RTL assertions check four things on every cycle:
- MDC only changes when the half-period count has expired.
- A parked MDC stays low.
- Every MDC transition carries a strobe with the matching tag.
- A register write is captured into the divide field.

The bench scenarios cover what needs a span of cycles:
- The exact high and low widths for several divide values, including 1.
- The start-up latency from the stopped state.
- The asymmetric half-phase around a divide change.
- Both orders of stopping, and the isolation of other addresses.

// File: rtl/mdc_div_pkg.sv
package mdc_div_pkg;
  localparam int unsigned DIV_LSB = 1;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_kind_e;
endpackage

// File: rtl/mdc_ctrl_reg.sv
module mdc_ctrl_reg #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIV_W     = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DIV_W-1:0]  div_val,
  output logic              skip_pre
);
  import mdc_div_pkg::*;
  localparam int unsigned PRE_BIT = DIV_LSB + DIV_W;

  logic hit;
  assign hit = reg_sel && (reg_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_val  <= '0;
      skip_pre <= 1'b0;
    end else if (hit && reg_wr) begin
      div_val  <= reg_wdata[DIV_LSB +: DIV_W];
      skip_pre <= reg_wdata[PRE_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      reg_rdata[DIV_LSB +: DIV_W] = div_val;
      reg_rdata[PRE_BIT]          = skip_pre;
    end
  end

  // R2: a write to the control address lands in the divide field
  assert_wr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && reg_wr) |=> (div_val == $past(reg_wdata[DIV_LSB +: DIV_W])));
endmodule

// File: rtl/mdc_half_div.sv
module mdc_half_div #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             mdc,
  output logic             stb,
  output logic             stb_rise
);
  import mdc_div_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic             run_q;
  logic             div_nz;

  assign div_nz = (div_val != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc      <= 1'b0;
      stb      <= 1'b0;
      stb_rise <= EDGE_FALL;
      cnt_q    <= '0;
      run_q    <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (!run_q) begin
        if (div_nz) begin
          run_q <= 1'b1;
          cnt_q <= div_val - 1'b1;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (div_nz) begin
        mdc      <= ~mdc;
        stb      <= 1'b1;
        stb_rise <= mdc ? EDGE_FALL : EDGE_RISE;
        cnt_q    <= div_val - 1'b1;
      end else begin
        if (mdc) begin
          mdc      <= 1'b0;
          stb      <= 1'b1;
          stb_rise <= EDGE_FALL;
        end
        run_q <= 1'b0;
      end
    end
  end

  // R4: MDC only moves once the half-period count has expired
  assert_hold_while_counting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0) |=> $stable(mdc));
  // R3: a parked clock stays low
  assert_zero_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_nz && !mdc) |=> !mdc);
  // R8: every transition carries a strobe
  assert_edge_has_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != $past(mdc)) |-> stb);
  // R8: the tag matches the new level
  assert_stb_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (stb_rise == mdc));
endmodule

// File: rtl/mdc_clk_divider.sv
module mdc_clk_divider #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIV_W     = 6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdc_stb,
  output logic              mdc_stb_rise,
  output logic              clk_running,
  output logic              skip_preamble
);
  logic [DIV_W-1:0] div_val;

  mdc_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .div_val(div_val), .skip_pre(skip_preamble)
  );

  mdc_half_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_val(div_val),
    .mdc(mdc), .stb(mdc_stb), .stb_rise(mdc_stb_rise)
  );

  assign clk_running = (div_val != '0);
endmodule

// File: tb/mdc_clk_divider_tb_top.sv
module mdc_clk_divider_tb_top;
  localparam int CLK_P = 10;
  localparam logic [7:0] CTRL = 8'h44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, mdc_stb, mdc_stb_rise, clk_running, skip_preamble;

  int total = 0;
  int bad = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic prev_mdc = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mdc_clk_divider dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdc_stb(mdc_stb), .mdc_stb_rise(mdc_stb_rise),
    .clk_running(clk_running), .skip_preamble(skip_preamble)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R8: strobe present exactly when MDC shows a new level, tag matches
  always @(negedge clk) begin
    if (mon_on && ((mdc !== prev_mdc) || mdc_stb)) begin
      chk("R8 strobe on transition", {31'd0, mdc_stb}, {31'd0, mdc !== prev_mdc});
      if (mdc_stb) chk("R8 edge tag", {31'd0, mdc_stb_rise}, {31'd0, mdc});
    end
    prev_mdc = mdc;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  // counts negedges until MDC leaves its current level
  task automatic wait_edge(output int n);
    logic l = mdc;
    n = 0;
    while (mdc == l && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic set_div(input int n);
    wr(CTRL, 32'(n) << 1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 mdc", {31'd0, mdc}, 0);
    chk("R1 stb", {31'd0, mdc_stb}, 0);
    chk("R1 running", {31'd0, clk_running}, 0);
    chk("R1 skip", {31'd0, skip_preamble}, 0);
    rd(CTRL, d);
    chk("R1 reg", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(CTRL, 32'hFFFF_FFFF);
    rd(CTRL, d);
    chk("R2 readback all ones", d, 32'h0000_00FE);
    chk("R9 skip out", {31'd0, skip_preamble}, 1);
    chk("R9 running", {31'd0, clk_running}, 1);
    wr(8'h40, 32'h0);
    rd(CTRL, d);
    chk("R2 other address write ignored", d, 32'h0000_00FE);
    rd(8'h40, d);
    chk("R2 other address reads zero", d, 0);
    wr(CTRL, 32'h0);
    chk("R9 skip cleared", {31'd0, skip_preamble}, 0);
    chk("R9 not running", {31'd0, clk_running}, 0);
    repeat (200) @(negedge clk);
  endtask

  task automatic t_zero();
    int seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mdc || mdc_stb) seen++;
    end
    chk("R3 held low with zero divide", seen, 0);
  endtask

  task automatic t_start(input int n);
    int k = 0;
    set_div(n);
    while (!mdc && k < 1000) begin
      @(negedge clk);
      k++;
    end
    chk($sformatf("R5 first rise latency N=%0d", n), k, n + 1);
  endtask

  task automatic t_period(input int n);
    int h;
    int l;
    t_start(n);
    for (int i = 0; i < 3; i++) begin
      wait_edge(h);
      wait_edge(l);
      chk($sformatf("R4 high width N=%0d", n), h, n);
      chk($sformatf("R4 low width N=%0d", n), l, n);
    end
  endtask

  task automatic stop_quiet();
    set_div(0);
    repeat (150) @(negedge clk);
  endtask

  task automatic t_change();
    int r;
    t_period(3);
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    set_div(5);
    wait_edge(r);
    chk("R6 high phase keeps old length", r + 1, 3);
    wait_edge(r);
    chk("R6 next low uses new value", r, 5);
    wait_edge(r);
    chk("R6 next high uses new value", r, 5);
  endtask

  task automatic t_stop_high();
    int r;
    int seen = 0;
    set_div(4);
    while (mdc) @(negedge clk);
    while (!mdc) @(negedge clk);
    set_div(0);
    chk("R9 running drops at write", {31'd0, clk_running}, 0);
    wait_edge(r);
    chk("R7 high phase finishes", r + 1, 4);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mdc) seen++;
    end
    chk("R7 stays low after stop", seen, 0);
  endtask

  task automatic t_stop_low();
    int seen = 0;
    set_div(4);
    while (!mdc) @(negedge clk);
    while (mdc) @(negedge clk);
    set_div(0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mdc || mdc_stb) seen++;
    end
    chk("R7 stop while low stays low", seen, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    prev_mdc = mdc;
    mon_on = 1'b1;
    t_reset();
    t_regs();
    t_zero();
    t_period(1);
    stop_quiet();
    t_period(2);
    stop_quiet();
    t_period(5);
    stop_quiet();
    t_period(7);
    stop_quiet();
    t_change();
    stop_quiet();
    t_stop_high();
    stop_quiet();
    t_stop_low();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule